// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block is the digital core that sits in front of a parallel-loaded digital-to-analog converter. A host writes a code word over a parallel data bus into a staging (input) register, and a separate active-low load strobe later moves that word into the output (DAC) register, whose contents drive the converter. Two extra paths exist. In transparent mode the bus word flows straight into both registers while the strobes are held. In readback mode the staging register is driven back onto the bus, so the host can verify a word before committing it.

All host controls are asynchronous to the block clock. Chip select, read/write, load strobe and reset-select each pass through a two-flop synchronizer. The bus word is delayed by the same number of stages so that it stays aligned with them. The active-low reset is asserted asynchronously and released synchronously. While it is held low, both registers are forced to a reset code, and the code follows reset-select live. The code is complementary: all ones is the zero (or negative full-scale) output, MSB clear with all other bits set is mid-scale (bipolar zero), and all zeros is positive full scale minus one LSB.

The DAC register is presented as a code output. A one-cycle update pulse accompanies every change of its value.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: While rstN is low, both registers are forced to the reset code: all ones when rstSel is 0, and MSB 0 with all other bits 1 when rstSel is 1. After release, dacCode and the readback word both show that code.
- R2: A change of rstSel while rstN stays low changes the forced code in both registers within four clock cycles.
- R3: Reset overrides every other control. Chip select, read/write and load activity during reset has no effect on either register.
- R4: With csN low, rdWr low (write) and ldN high, the bus word is captured into the input register once, when csN rises. dacCode does not change.
- R5: With csN high and ldN low, the DAC register takes the input register value, and the input register keeps its value.
- R6: With csN, rdWr and ldN all low, the bus word goes into both registers and keeps following the bus while that state lasts.
- R7: With csN low and rdWr high (read), busOe is 1 and busOut carries the input register, whatever the level of ldN. Neither register changes.
- R8: busOe is 0 and busOut is all zeros whenever the block is not in a read.
- R9: With csN high and ldN high, neither register changes, whatever the values on the bus and on rdWr.
- R10: dacUpd is high for exactly one cycle each time the DAC register value changes. It stays low when a load writes the value the register already holds.
- R11: A register update caused by a control input that changes just after a falling clock edge appears on dacCode after the third rising edge that follows, with dacUpd high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset, asserted asynchronously, held as a level |
| rstSel | input | 1 | Reset code select: 1 gives mid-scale, 0 gives all ones |
| csN | input | 1 | Active-low chip select |
| rdWr | input | 1 | 1 = read the input register, 0 = write |
| ldN | input | 1 | Active-low load strobe into the DAC register |
| busIn | input | DATA_W | Bus word from the host |
| busOut | output | DATA_W | Readback word, all zeros when not enabled |
| busOe | output | 1 | Bus drive enable for the readback word |
| dacCode | output | DATA_W | DAC register contents sent to the converter |
| dacUpd | output | 1 | One-cycle pulse when dacCode changes |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. With eight bits, every code from 0x00 to 0xFF can be written, read back and loaded in a single run, and both reset codes (0xFF and 0x7F) are reached.

Two synchronizer stages fix the control-to-output latency at three rising edges. The bench checks that latency cycle-exactly and counts update pulses against the number of value changes it predicts. Transparent writes are swept over a spread of codes, each followed by a change of the live bus word.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

  // Per-cycle command from the control unit to the datapath.
  typedef struct packed {
    logic forceRst;   // reset held: load reset code into both registers
    logic forceMid;   // reset code choice: 1 = mid-scale, 0 = all ones
    logic capIn;      // input register takes the bus word
    logic dacFromBus; // DAC register takes the bus word
    logic dacFromIn;  // DAC register takes the input register
  } dacStrobe_t;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/dac_ctrl_logic.sv
module dac_ctrl_logic
  import dac_dbuf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstSel,
  input  logic       csN,
  input  logic       rdWr,
  input  logic       ldN,
  output dacStrobe_t strb,
  output logic       busOe
);

  localparam int CTL_W = 3;

  logic rstSyncN;
  logic [CTL_W-1:0] ctlQ;
  logic csS, rwS, ldS, selS;
  logic csPrev, rwPrev;
  logic csRise, wrEdge, transp;

  // Reset: asserted at once, released after SYNC_STAGES edges.
  dac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rstSync (
    .clk(clk), .rstN(rstN), .d(1'b1), .q(rstSyncN)
  );

  // Host controls, idle values while reset is held.
  dac_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctlSync (
    .clk(clk), .rstN(rstSyncN), .d({csN, rdWr, ldN}), .q(ctlQ)
  );
  assign {csS, rwS, ldS} = ctlQ;

  // Reset-select keeps running during reset so the code can track it.
  dac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_selSync (
    .clk(clk), .rstN(1'b1), .d(rstSel), .q(selS)
  );

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      csPrev <= 1'b1;
      rwPrev <= 1'b1;
    end else begin
      csPrev <= csS;
      rwPrev <= rwS;
    end
  end

  assign csRise = csS & ~csPrev;
  assign wrEdge = csRise & ~rwPrev;
  assign transp = ~csS & ~rwS & ~ldS;

  always_comb begin
    strb          = '0;
    strb.forceMid = selS;
    if (!rstSyncN) begin
      strb.forceRst = 1'b1;
    end else if (transp) begin
      strb.capIn      = 1'b1;
      strb.dacFromBus = 1'b1;
    end else if (wrEdge) begin
      strb.capIn      = 1'b1;
      strb.dacFromBus = ~ldS;
    end else if (csS && !ldS) begin
      strb.dacFromIn = 1'b1;
    end
  end

  assign busOe = rstSyncN & ~csS & rwS;

  // R4: a buffered capture fires once per chip-select rising edge
  a_r4_single_capture: assert property (@(posedge clk) disable iff (!rstSyncN)
    (strb.capIn && !strb.dacFromBus) |=> !(strb.capIn && !strb.dacFromBus));

  // R7: a read never coincides with a register write command
  a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rstSyncN)
    busOe |-> !(strb.capIn || strb.dacFromBus || strb.dacFromIn));

endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_dbuf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  dacStrobe_t        strb,
  input  logic [DATA_W-1:0] busIn,
  input  logic              busOe,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] dacCode,
  output logic              dacUpd
);

  localparam logic [DATA_W-1:0] MIN_CODE = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] MID_CODE = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] busS;
  logic [DATA_W-1:0] inReg, dacReg;
  logic [DATA_W-1:0] inNext, dacNext, forcedCode;

  // Bus word delayed to stay aligned with the synchronized strobes.
  dac_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busSync (
    .clk(clk), .rstN(1'b1), .d(busIn), .q(busS)
  );

  assign forcedCode = strb.forceMid ? MID_CODE : MIN_CODE;

  always_comb begin
    inNext  = inReg;
    dacNext = dacReg;
    if (strb.forceRst) begin
      inNext  = forcedCode;
      dacNext = forcedCode;
    end else begin
      if (strb.capIn)      inNext  = busS;
      if (strb.dacFromBus) dacNext = busS;
      else if (strb.dacFromIn) dacNext = inReg;
    end
  end

  always_ff @(posedge clk) begin
    inReg  <= inNext;
    dacReg <= dacNext;
    dacUpd <= (dacNext != dacReg);
  end

  assign dacCode = dacReg;
  assign busOut  = busOe ? inReg : '0;

  // R1: reset loads one of the two reset codes into both registers
  a_r1_reset_code: assert property (@(posedge clk)
    strb.forceRst |=> (inReg == dacReg) &&
                      (dacReg == ($past(strb.forceMid) ? MID_CODE : MIN_CODE)));

  // R5: a load copies the staging word and leaves the staging register alone
  a_r5_load_copy: assert property (@(posedge clk) disable iff (strb.forceRst)
    strb.dacFromIn |=> (dacReg == $past(inReg)) && $stable(inReg));

  // R9: no command means both registers hold
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (strb.forceRst)
    !(strb.capIn || strb.dacFromBus || strb.dacFromIn) |=> $stable(inReg) && $stable(dacReg));

  // R10: the update pulse marks a change of the DAC register, and only that
  a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (strb.forceRst)
    dacUpd |-> (dacReg != $past(dacReg)));

endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
  import dac_dbuf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstSel,
  input  logic              csN,
  input  logic              rdWr,
  input  logic              ldN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] dacCode,
  output logic              dacUpd
);

  dacStrobe_t strb;

  dac_ctrl_logic #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rstSel(rstSel), .csN(csN), .rdWr(rdWr), .ldN(ldN),
    .strb(strb), .busOe(busOe)
  );

  dac_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .strb(strb), .busIn(busIn), .busOe(busOe),
    .busOut(busOut), .dacCode(dacCode), .dacUpd(dacUpd)
  );

  // R7: while the bus is driven for readback the DAC code holds
  a_r7_read_holds_dac: assert property (@(posedge clk) disable iff (!rstN)
    busOe |=> $stable(dacCode));

endmodule

// File: tb/test_dac_dbuf_ctrl.sv
module test_dac_dbuf_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] MINC = {W{1'b1}};
  localparam logic [W-1:0] MIDC = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0;
  logic rstN = 1'b0, rstSel = 1'b0, csN = 1'b1, rdWr = 1'b0, ldN = 1'b1;
  logic [W-1:0] busIn = '0;
  logic [W-1:0] busOut, dacCode;
  logic busOe, dacUpd;

  int nRun = 0, nFail = 0, updCount = 0;
  logic [W-1:0] expIn, expDac;

  dac_dbuf_ctrl #(.DATA_W(W), .SYNC_STAGES(2)) i_dac_dbuf_ctrl (
    .clk(clk), .rstN(rstN), .rstSel(rstSel), .csN(csN), .rdWr(rdWr), .ldN(ldN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .dacCode(dacCode), .dacUpd(dacUpd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (dacUpd === 1'b1) updCount++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [W-1:0] v);
    busIn = v; rdWr = 1'b0; ldN = 1'b1;
    tick(1);
    csN = 1'b0;
    tick(3);
    csN = 1'b1;
    tick(4);
    expIn = v;
  endtask

  task automatic doLoad();
    ldN = 1'b0;
    tick(4);
    ldN = 1'b1;
    tick(2);
    expDac = expIn;
  endtask

  task automatic doRead(string req);
    rdWr = 1'b1;
    tick(1);
    csN = 1'b0;
    tick(4);
    check({req, " read enable"}, busOe, 1);
    check({req, " readback"}, busOut, expIn);
    csN = 1'b1;
    tick(3);
    rdWr = 1'b0;
    tick(1);
    check("R8 enable off", busOe, 0);
    check("R8 bus zero", busOut, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int c0;
    logic [W-1:0] prev;
    // R1: reset state, all-ones code
    tick(6);
    check("R1 min code in reset", dacCode, MINC);
    check("R8 no drive in reset", busOe, 0);
    // R2: live tracking of reset-select
    rstSel = 1'b1; tick(4);
    check("R2 track to mid", dacCode, MIDC);
    rstSel = 1'b0; tick(4);
    check("R2 track to min", dacCode, MINC);
    rstSel = 1'b1; tick(4);
    rstN = 1'b1; tick(4);
    check("R1 mid code after release", dacCode, MIDC);
    expIn = MIDC; expDac = MIDC;
    doRead("R1");

    // R4 R5 R7 R10: every code written, read back, loaded
    for (int v = 0; v < (1 << W); v++) begin
      prev = expDac;
      c0 = updCount;
      doWrite(v[W-1:0]);
      check("R4 dac holds on write", dacCode, expDac);
      doRead("R7");
      doLoad();
      check("R5 load result", dacCode, expIn);
      check("R10 pulse count", updCount - c0, (expIn != prev) ? 1 : 0);
      if (v % 32 == 0) doRead("R5 input kept");
    end

    // R11: exact latency of a load
    prev = expDac;
    doWrite(8'hA5);
    c0 = updCount;
    ldN = 1'b0;
    tick(2);
    check("R11 not yet after two edges", dacCode, prev);
    tick(1);
    check("R11 updated at third edge", dacCode, 8'hA5);
    check("R11 pulse with new value", dacUpd, 1);
    tick(1);
    check("R10 pulse one cycle", dacUpd, 0);
    ldN = 1'b1; tick(2);
    check("R10 single pulse", updCount - c0, 1);
    expDac = 8'hA5;

    // R9: idle with bus and rdWr wiggling
    c0 = updCount;
    busIn = 8'h3C; tick(2); rdWr = 1'b1; tick(2); busIn = 8'hC3; rdWr = 1'b0; tick(4);
    check("R9 dac holds", dacCode, expDac);
    check("R9 no pulse", updCount - c0, 0);
    doRead("R9");

    // R10: load of an identical value gives no pulse
    c0 = updCount;
    doWrite(expDac);
    doLoad();
    check("R10 same value no pulse", updCount - c0, 0);

    // R7: read with load strobe low leaves the DAC register alone
    doWrite(8'h11);
    rdWr = 1'b1; tick(1);
    csN = 1'b0; tick(3);
    ldN = 1'b0; tick(3);
    check("R7 enable with load low", busOe, 1);
    check("R7 readback with load low", busOut, 8'h11);
    check("R7 dac holds during read", dacCode, expDac);
    ldN = 1'b1; tick(3);
    csN = 1'b1; tick(3);
    rdWr = 1'b0; tick(1);
    check("R7 dac holds after read", dacCode, expDac);

    // R6: transparent mode over a spread of codes
    for (int v = 0; v < (1 << W); v += 15) begin
      rdWr = 1'b0; busIn = v[W-1:0]; tick(1);
      csN = 1'b0; ldN = 1'b0; tick(4);
      check("R6 transparent", dacCode, v[W-1:0]);
      busIn = v[W-1:0] ^ 8'h5A; tick(4);
      check("R6 follows bus", dacCode, v[W-1:0] ^ 8'h5A);
      csN = 1'b1; tick(4);
      ldN = 1'b1; tick(2);
      expIn = v[W-1:0] ^ 8'h5A; expDac = expIn;
      check("R6 dac after exit", dacCode, expDac);
      doRead("R6");
    end

    // R3: reset overrides an active transparent write
    rstSel = 1'b0; tick(3);
    csN = 1'b0; rdWr = 1'b0; ldN = 1'b0; busIn = 8'h42; rstN = 1'b0;
    tick(3);
    check("R3 reset wins", dacCode, MINC);
    tick(3);
    check("R3 reset still wins", dacCode, MINC);
    csN = 1'b1; ldN = 1'b1; tick(2);
    rstN = 1'b1; tick(4);
    check("R3 code after release", dacCode, MINC);
    expIn = MINC; expDac = MINC;
    doRead("R3");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule